// File: doc/BRIEF.md
# Dual-Channel Non-Retriggerable One-Shot

This block produces one output pulse per qualifying trigger event. The pulse length is counted in clock cycles. Each channel has two trigger pins. One fires when it falls while the other pin is high. The other fires when it rises while the first pin is low. So each trigger pin also acts as an enable for its partner.

An active-low clear pin overrides all other inputs. It cuts a running pulse short and keeps the outputs idle for as long as it stays low. If the trigger pins already sit in their firing combination when the clear is released, that release starts a pulse.

Every input is brought into the clock domain by a two-flop synchronizer. Internally, triggering is a single rule: a rising edge of the term "fall pin low AND rise pin high AND clear high". This rule is only evaluated while the channel is idle.

The pulse length comes from a per-channel length input and is captured when the pulse starts. A programmed length L gives a pulse of L+1 cycles. Each pulse appears on a true output and on its complement. The top instantiates the channels side by side, and they share nothing but the clock and the reset.

Top module: `oneshot_pair`

## Requirements
- R1: While reset is asserted and directly after it, every channel drives pulse low and pulseN high.
- R2: A falling fallTrig while riseTrig is high and clearN is high starts a pulse. If the fall is first sampled at clock edge k, pulse is high after edge k+2.
- R3: A rising riseTrig while fallTrig is low and clearN is high starts a pulse, with the same two-edge latency as R2.
- R4: With length value L (bits [c*WIDTH +: WIDTH] of pulseLen for channel c) sampled at the edge where the pulse begins, pulse stays high for exactly L+1 cycles. L = 0 gives one cycle. A change of pulseLen during the pulse has no effect on it.
- R5: Non-retriggerable: any trigger activity while a pulse is high leaves its length unchanged. A firing combination that is still held when the pulse ends does not start another pulse.
- R6: clearN low, first sampled at edge k, drives pulse low after edge k+2 and holds it low while clearN stays low. Clear wins over any trigger in the same cycle.
- R7: A rise of clearN while fallTrig is low and riseTrig is high starts a pulse, with the same latency as R2.
- R8: While fallTrig is held high or riseTrig is held low, no new pulse begins. A pulse already running when that condition arises still runs its full length.
- R9: pulseN is always the complement of pulse.
- R10: Channels are independent: stimulus on one channel never changes the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fallTrig | input | CHANNELS | Falling-edge trigger pins, one per channel |
| riseTrig | input | CHANNELS | Rising-edge trigger pins, one per channel |
| clearN | input | CHANNELS | Active-low overriding clear, one per channel |
| pulseLen | input | CHANNELS*WIDTH | Per-channel length value L (pulse is L+1 cycles) |
| pulse | output | CHANNELS | High-going output pulse |
| pulseN | output | CHANNELS | Low-going complementary output pulse |

## Verification
A stale busy flag is visible at the ports. It shows up as a pulse that does not end, or as a retrigger that lengthens a pulse. Both are caught in the first cycle where pulse differs from the model's remaining-cycle count.

A down-counter that is wrong or loaded with the wrong value shifts the falling edge of pulse. The mismatch is seen within L+1 cycles of the start. A broken edge memory produces a spurious second pulse one cycle after the first one ends, or a missing pulse two edges after the trigger. Since the bench compares every output on every cycle, any such fault is reported in the cycle it first becomes visible.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic load;   // capture length, pulse begins
    logic dec;    // count one cycle of a running pulse
    logic clr;    // synchronized clear is active
  } osStrobe_t;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [STAGES-1:0][N-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RST_VAL;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/os_ctrl.sv
module os_ctrl
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      aSync,
  input  logic      bSync,
  input  logic      clrSync,
  input  logic      cntZero,
  output osStrobe_t strobe,
  output logic      active
);
  logic armTerm;
  logic termPrev;
  logic fire;

  assign armTerm = ~aSync & bSync & clrSync;
  assign fire    = armTerm & ~termPrev & ~active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termPrev <= 1'b0;
      active   <= 1'b0;
    end else begin
      termPrev <= armTerm;
      if (!clrSync)              active <= 1'b0;
      else if (fire)             active <= 1'b1;
      else if (active && cntZero) active <= 1'b0;
    end
  end

  assign strobe.load = fire;
  assign strobe.dec  = active & ~cntZero;
  assign strobe.clr  = ~clrSync;

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !clrSync |=> !active); // R6
  AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> active); // R2
  AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rstN)
    (active && !cntZero && clrSync) |=> active); // R5
  AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!active && (aSync || !bSync)) |=> !active); // R8
endmodule

// File: rtl/os_dp.sv
module os_dp
  import oneshot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  osStrobe_t        strobe,
  input  logic [WIDTH-1:0] lenIn,
  output logic             cntZero
);
  logic [WIDTH-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            remain <= '0;
    else if (strobe.clr)  remain <= '0;
    else if (strobe.load) remain <= lenIn;
    else if (strobe.dec)  remain <= remain - 1'b1;
  end

  assign cntZero = (remain == '0);

  AST_LEN_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.clr) |=> remain == $past(lenIn)); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.clr && !strobe.load) |=> remain == $past(remain) - 1'b1); // R4
endmodule

// File: rtl/os_channel.sv
module os_channel
  import oneshot_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fallIn,
  input  logic             riseIn,
  input  logic             clearIn,
  input  logic [WIDTH-1:0] lenIn,
  output logic             pulseOut,
  output logic             pulseOutN
);
  logic [2:0] syncd;
  osStrobe_t  strobe;
  logic       cntZero;
  logic       active;

  // bit 2 = fall pin (idles high), bit 1 = rise pin, bit 0 = clear
  os_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({fallIn, riseIn, clearIn}),
    .dout(syncd)
  );

  os_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .aSync(syncd[2]), .bSync(syncd[1]), .clrSync(syncd[0]),
    .cntZero(cntZero), .strobe(strobe), .active(active)
  );

  os_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lenIn(lenIn), .cntZero(cntZero)
  );

  assign pulseOut  = active;
  assign pulseOutN = ~active;
endmodule

// File: rtl/oneshot_pair.sv
module oneshot_pair #(
  parameter int CHANNELS = 2,
  parameter int WIDTH    = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CHANNELS-1:0]       fallTrig,
  input  logic [CHANNELS-1:0]       riseTrig,
  input  logic [CHANNELS-1:0]       clearN,
  input  logic [CHANNELS*WIDTH-1:0] pulseLen,
  output logic [CHANNELS-1:0]       pulse,
  output logic [CHANNELS-1:0]       pulseN
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    os_channel #(.WIDTH(WIDTH)) u_ch (
      .clk(clk), .rstN(rstN),
      .fallIn(fallTrig[c]), .riseIn(riseTrig[c]), .clearIn(clearN[c]),
      .lenIn(pulseLen[c*WIDTH +: WIDTH]),
      .pulseOut(pulse[c]), .pulseOutN(pulseN[c])
    );
  end
endmodule

// File: tb/sim_oneshot_pair.sv
`timescale 1ns/1ps
module sim_oneshot_pair;
  localparam int CH = 2;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CH-1:0] fallTrig = '1;
  logic [CH-1:0] riseTrig = '0;
  logic [CH-1:0] clearN = '1;
  logic [CH*W-1:0] pulseLen = '0;
  logic [CH-1:0] pulse, pulseN;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 0;

  oneshot_pair #(.CHANNELS(CH), .WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .fallTrig(fallTrig), .riseTrig(riseTrig),
    .clearN(clearN), .pulseLen(pulseLen), .pulse(pulse), .pulseN(pulseN)
  );

  always #2 clk = ~clk;  // 250 MHz

  // behavioural reference: two-deep input delay, remaining-cycle count
  bit a1[CH], a2[CH], b1[CH], b2[CH], c1[CH], c2[CH], prevT[CH];
  int rem[CH];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CH; c++) begin
        a1[c] = 1; a2[c] = 1; b1[c] = 0; b2[c] = 0; c1[c] = 0; c2[c] = 0;
        prevT[c] = 0; rem[c] = 0;
      end
    end else begin
      for (int c = 0; c < CH; c++) begin
        bit t;
        t = !a2[c] && b2[c] && c2[c];
        if (!c2[c]) rem[c] = 0;
        else if (rem[c] == 0 && t && !prevT[c]) rem[c] = int'(pulseLen[c*W +: W]) + 1;
        else if (rem[c] > 0) rem[c] = rem[c] - 1;
        prevT[c] = t;
        a2[c] = a1[c]; b2[c] = b1[c]; c2[c] = c1[c];
        a1[c] = fallTrig[c]; b1[c] = riseTrig[c]; c1[c] = clearN[c];
      end
    end
  end

  task automatic compare();
    for (int c = 0; c < CH; c++) begin
      bit expQ;
      expQ = (rem[c] > 0);
      checks++;
      if (pulse[c] !== expQ) begin
        errors++;
        $display("FAIL %s ch%0d pulse t=%0t actual=%b expected=%b", curReq, c, $time, pulse[c], expQ);
      end
      checks++;
      if (pulseN[c] !== ~pulse[c]) begin  // R9
        errors++;
        $display("FAIL R9 ch%0d pulseN t=%0t actual=%b expected=%b", c, $time, pulseN[c], ~pulse[c]);
      end
    end
  endtask

  always @(negedge clk) if (rstN) compare();

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLen(int c, int v);
    pulseLen[c*W +: W] = W'(v);
  endtask

  initial begin
    // R1: reset state
    cyc(2);
    for (int c = 0; c < CH; c++) begin
      checks++;
      if (pulse[c] !== 1'b0 || pulseN[c] !== 1'b1) begin
        errors++;
        $display("FAIL R1 ch%0d actual=%b%b expected=01", c, pulse[c], pulseN[c]);
      end
    end
    rstN = 1'b1;
    cyc(4);

    // R2: fall edge with rise pin high
    curReq = "R2";
    setLen(0, 4);
    riseTrig[0] = 1; cyc(2);
    fallTrig[0] = 0; cyc(2);
    fallTrig[0] = 1; cyc(8);

    // R3: rise edge with fall pin low; R4 length 0 -> one cycle
    curReq = "R3";
    setLen(0, 0);
    riseTrig[0] = 0; fallTrig[0] = 0; cyc(3);
    riseTrig[0] = 1; cyc(1);
    riseTrig[0] = 0; cyc(5);

    // R4: length change during pulse ignored
    curReq = "R4";
    setLen(0, 6);
    riseTrig[0] = 1; cyc(3);
    setLen(0, 1); cyc(10);
    riseTrig[0] = 0; cyc(2);

    // R5: retrigger ignored; condition held past the end gives no new pulse
    curReq = "R5";
    setLen(0, 7);
    riseTrig[0] = 1; cyc(3);
    for (int i = 0; i < 3; i++) begin
      riseTrig[0] = 0; cyc(1); riseTrig[0] = 1; cyc(1);
    end
    cyc(15);
    riseTrig[0] = 0; cyc(3);

    // R6: clear cuts a pulse short, clear held with trigger activity
    curReq = "R6";
    setLen(0, 20);
    riseTrig[0] = 1; cyc(4);
    clearN[0] = 0; cyc(4);
    riseTrig[0] = 0; cyc(1); riseTrig[0] = 1; cyc(3);
    riseTrig[0] = 0; fallTrig[0] = 1; cyc(2);

    // R7: clear release with fall low / rise high starts a pulse
    curReq = "R7";
    setLen(0, 3);
    fallTrig[0] = 0; riseTrig[0] = 1; cyc(3);
    clearN[0] = 1; cyc(10);
    riseTrig[0] = 0; fallTrig[0] = 1; cyc(2);

    // R8: blocked while fall pin high / rise pin low; running pulse survives
    curReq = "R8";
    setLen(0, 5);
    riseTrig[0] = 1; cyc(1);
    for (int i = 0; i < 3; i++) begin
      riseTrig[0] = 0; cyc(1); riseTrig[0] = 1; cyc(1);
    end
    riseTrig[0] = 0; fallTrig[0] = 0; cyc(1);
    fallTrig[0] = 1; fallTrig[0] = 0; cyc(1);
    for (int i = 0; i < 3; i++) begin
      fallTrig[0] = 1; cyc(1); fallTrig[0] = 0; cyc(1);
    end
    riseTrig[0] = 1; cyc(3);
    fallTrig[0] = 1; riseTrig[0] = 0; cyc(10);

    // R10: channel 1 alone, then both overlapped with a clear on channel 0
    curReq = "R10";
    setLen(1, 9); setLen(0, 2);
    riseTrig[1] = 1; cyc(1);
    fallTrig[1] = 0; cyc(14);
    fallTrig[1] = 1; riseTrig[1] = 0; cyc(2);
    riseTrig[0] = 1; riseTrig[1] = 1; cyc(1);
    fallTrig[1] = 0; cyc(1);
    fallTrig[0] = 0; clearN[0] = 0; cyc(6);
    clearN[0] = 1; cyc(14);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog t=%0t actual=running expected=finished", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule